// File: doc/BRIEF.md
# Command-Table ADC Scan Sequencer

This block walks a table of conversion command words so that an external analog-to-digital converter can take a series of samples with no processor help between them. Each table word names an input channel and a sample-time code. For every word the sequencer drives the channel number, holds a sample request for the coded number of clocks, then pulses a start strobe. It waits for the converter's done handshake and stores the 10-bit result in a result memory at the same index as the command word.

Software fills the table, sets the scan mode and picks the trigger source through a word-addressed register port. The scan mode is one pass per trigger or repeated passes. The trigger source is a software start bit, a rising edge on an external pin, or a programmable interval timer. At the end of each pass a completion flag is set, and it raises an interrupt when enabled. Each result can be read through three windows, each giving a different bit alignment.

Top module: `adc_cmd_sequencer`

## Requirements
- R1: A command word holds the channel in bits [5:0] and a sample-time code in bits [7:6]. Codes 0..3 give 2, 4, 8 and 16 clocks. For a command, `cv_chan` carries the channel and `cv_sample` is high for exactly that many consecutive clocks. It is followed directly by a one-clock `cv_start` pulse, with `cv_chan` held stable.
- R2: A command word whose channel field is 63 ends the pass, and no conversion is issued for it.
- R3: The converter result for the command at index i is readable at index i of the result windows.
- R4: With control bit [0] at 0, a trigger makes exactly one pass over the table, and the block then stays idle.
- R5: With control bit [0] at 1, the walk restarts at index 0 after each end of pass. If the bit is cleared during a pass, that pass still completes, and no further pass starts.
- R6: Control bits [2:1] choose the trigger source. 0 selects the start bit (control bit [4], write 1). 1 selects a rising edge on `ext_trig`. 2 selects the interval timer, which fires every N clocks, where N is the value at address 0x002 (0 stops it). 3 selects none. Triggers from sources that are not selected have no effect.
- R7: Status bit [0] is set at the end of every pass and is cleared by writing 1 to it. `irq` is high while this bit is set and control bit [3] is 1.
- R8: Result reads: address 0x200+i returns the result in bits [9:0] with zeros above. Address 0x240+i returns it in bits [15:6] with zeros below. Address 0x280+i returns the same as 0x240+i but with bit 15 inverted.
- R9: A trigger that arrives while a pass is running is ignored and sets the sticky status bit [1], which is cleared by writing 1 to it.
- R10: The table holds 64 words (write address 0x100+i). A pass that finishes index 63 without meeting channel 63 ends as if the end code had been read.
- R11: Status bits [13:8] hold the index of the current command word. After a pass, this is the index at which the pass ended.
- R12: After reset the status reads 0, `irq`, `cv_sample` and `cv_start` are low, the trigger source is the start bit and the mode is single pass. Register reads return data in the clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 10 | Register word address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, one clock after the address |
| ext_trig | input | 1 | External trigger pin (rising edge) |
| cv_sample | output | 1 | Sample request to the converter |
| cv_start | output | 1 | Conversion start pulse |
| cv_chan | output | 6 | Channel to convert |
| cv_done | input | 1 | Converter done handshake |
| cv_result | input | 10 | Converter result, valid with `cv_done` |
| irq | output | 1 | Pass-complete interrupt |

## Verification
The hardest case to reach is a mode change in the middle of a repeating scan: clearing the repeat bit must let the running pass finish and must not start another. The bench preloads its scoreboard with three passes of expected conversions. It watches the conversion count and clears the mode bit while the converter model is still working on the second pass. It then checks that exactly one pass's worth of expected items was never consumed. An overrun is reached by reissuing the start bit a few clocks into a pass. A run over the full table with no end code covers the end-at-last-index case.

// File: rtl/qseq_pkg.sv
package qseq_pkg;
  localparam int CHAN_W = 6;
  localparam int ST_W   = 2;
  localparam int CCW_W  = CHAN_W + ST_W;
  localparam int RES_W  = 10;
  localparam int WORD_W = 16;
  localparam logic [CHAN_W-1:0] EOQ_CHAN = '1;

  typedef enum logic [1:0] {
    SRC_SW  = 2'd0,
    SRC_PIN = 2'd1,
    SRC_TMR = 2'd2,
    SRC_OFF = 2'd3
  } trig_src_t;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_DECODE, S_SAMPLE, S_CONV, S_STORE
  } eng_state_t;
endpackage

// File: rtl/qseq_sdp_ram.sv
module qseq_sdp_ram #(
  parameter int DW = 8,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/qseq_trigger.sv
module qseq_trigger
  import qseq_pkg::*;
#(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  trig_src_t        src,
  input  logic             sw_start,
  input  logic             ext_pin,
  input  logic [TMR_W-1:0] period,
  output logic             trig
);
  logic             pin_s1, pin_s2, pin_prev;
  logic [TMR_W-1:0] tmr_q;
  logic             tmr_run, tmr_hit;

  assign tmr_run = (src == SRC_TMR) && (period != '0);
  assign tmr_hit = tmr_run && (tmr_q == period - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_s1 <= 1'b0; pin_s2 <= 1'b0; pin_prev <= 1'b0;
      tmr_q  <= '0;   trig   <= 1'b0;
    end else begin
      pin_s1   <= ext_pin;
      pin_s2   <= pin_s1;
      pin_prev <= pin_s2;
      if (!tmr_run || tmr_hit) tmr_q <= '0;
      else                     tmr_q <= tmr_q + 1'b1;
      trig <= ((src == SRC_SW)  && sw_start) ||
              ((src == SRC_PIN) && pin_s2 && !pin_prev) ||
              tmr_hit;
    end
  end

  AST_TRIG_NOT_OFF: assert property (@(posedge clk) disable iff (rst)
    trig |-> ($past(src) != SRC_OFF)); // R6
endmodule

// File: rtl/qseq_engine.sv
module qseq_engine
  import qseq_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              cont_mode,
  output logic [IDX_W-1:0]  ccw_addr,
  input  logic [CCW_W-1:0]  ccw_data,
  output logic              res_we,
  output logic [IDX_W-1:0]  res_addr,
  output logic [RES_W-1:0]  res_wdata,
  output logic              busy,
  output logic              pass_done,
  output logic [IDX_W-1:0]  idx_o,
  output logic              cv_sample,
  output logic              cv_start,
  output logic [CHAN_W-1:0] cv_chan,
  input  logic              cv_done,
  input  logic [RES_W-1:0]  cv_result
);
  localparam int CNT_W = 1 << ST_W;
  localparam logic [IDX_W-1:0] LAST_IDX = '1;

  eng_state_t        state;
  logic [IDX_W-1:0]  idx_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [RES_W-1:0]  res_q;
  logic [CHAN_W-1:0] ccw_chan;
  logic [ST_W-1:0]   ccw_st;
  logic [CNT_W-1:0]  samp_m1;

  assign ccw_chan  = ccw_data[CHAN_W-1:0];
  assign ccw_st    = ccw_data[CCW_W-1:CHAN_W];
  assign samp_m1   = CNT_W'((2 << ccw_st) - 1);
  assign ccw_addr  = idx_q;
  assign res_addr  = idx_q;
  assign res_wdata = res_q;
  assign res_we    = (state == S_STORE);
  assign busy      = (state != S_IDLE);
  assign idx_o     = idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      idx_q     <= '0;
      cnt_q     <= '0;
      res_q     <= '0;
      cv_sample <= 1'b0;
      cv_start  <= 1'b0;
      cv_chan   <= '0;
      pass_done <= 1'b0;
    end else begin
      pass_done <= 1'b0;
      unique case (state)
        S_IDLE: if (start) begin
          idx_q <= '0;
          state <= S_FETCH;
        end
        S_FETCH: state <= S_DECODE;
        S_DECODE: begin
          if (ccw_chan == EOQ_CHAN) begin
            pass_done <= 1'b1;
            if (cont_mode) begin idx_q <= '0; state <= S_FETCH; end
            else state <= S_IDLE;
          end else begin
            cv_chan   <= ccw_chan;
            cnt_q     <= samp_m1;
            cv_sample <= 1'b1;
            state     <= S_SAMPLE;
          end
        end
        S_SAMPLE: begin
          if (cnt_q == '0) begin
            cv_sample <= 1'b0;
            cv_start  <= 1'b1;
            state     <= S_CONV;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        S_CONV: begin
          cv_start <= 1'b0;
          if (cv_done) begin
            res_q <= cv_result;
            state <= S_STORE;
          end
        end
        S_STORE: begin
          if (idx_q == LAST_IDX) begin
            pass_done <= 1'b1;
            if (cont_mode) begin idx_q <= '0; state <= S_FETCH; end
            else state <= S_IDLE;
          end else begin
            idx_q <= idx_q + 1'b1;
            state <= S_FETCH;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_SAMPLE_THEN_START: assert property (@(posedge clk) disable iff (rst)
    !(cv_sample && cv_start)); // R1
  AST_START_ONE_CLOCK: assert property (@(posedge clk) disable iff (rst)
    cv_start |=> !cv_start); // R1
  AST_CHAN_HELD: assert property (@(posedge clk) disable iff (rst)
    cv_sample |=> $stable(cv_chan)); // R1
  AST_NO_EOQ_CONV: assert property (@(posedge clk) disable iff (rst)
    cv_start |-> (cv_chan != EOQ_CHAN)); // R2
  AST_STORE_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    res_we |-> $past(cv_done)); // R3
endmodule

// File: rtl/adc_cmd_sequencer.sv
module adc_cmd_sequencer
  import qseq_pkg::*;
#(
  parameter int IDX_W  = 6,
  parameter int TMR_W  = 16,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  input  logic              ext_trig,
  output logic              cv_sample,
  output logic              cv_start,
  output logic [CHAN_W-1:0] cv_chan,
  input  logic              cv_done,
  input  logic [RES_W-1:0]  cv_result,
  output logic              irq
);
  localparam int OFF_W = ADDR_W - 2;
  localparam logic [1:0] RG_CSR = 2'd0;
  localparam logic [1:0] RG_CCW = 2'd1;
  localparam logic [1:0] RG_RES = 2'd2;
  localparam logic [OFF_W-1:0] A_CTL = OFF_W'(0);
  localparam logic [OFF_W-1:0] A_STS = OFF_W'(1);
  localparam logic [OFF_W-1:0] A_TMR = OFF_W'(2);
  localparam int PAD_W = WORD_W - RES_W;

  logic [1:0]       region;
  logic [OFF_W-1:0] off;
  logic             wr_ctl, wr_sts, wr_tmr, wr_ccw;
  logic             cont_q, ie_q, sw_q, cmp_q, ovr_q, cmp_d;
  trig_src_t        src_q;
  logic [TMR_W-1:0] period_q;
  logic             trig, busy, pass_done;
  logic [IDX_W-1:0] idx, ccw_raddr, res_waddr;
  logic [CCW_W-1:0] ccw_rdata;
  logic             res_we;
  logic [RES_W-1:0] res_wdata, res_rdata;
  logic [1:0]       region_q, view_q;
  logic [WORD_W-1:0] csr_q, csr_d;

  assign region = reg_addr[ADDR_W-1 -: 2];
  assign off    = reg_addr[OFF_W-1:0];
  assign wr_ctl = reg_wr && region == RG_CSR && off == A_CTL;
  assign wr_sts = reg_wr && region == RG_CSR && off == A_STS;
  assign wr_tmr = reg_wr && region == RG_CSR && off == A_TMR;
  assign wr_ccw = reg_wr && region == RG_CCW;

  assign cmp_d = pass_done || (cmp_q && !(wr_sts && reg_wdata[0]));

  always_ff @(posedge clk) begin
    if (rst) begin
      cont_q <= 1'b0; ie_q <= 1'b0; sw_q <= 1'b0; src_q <= SRC_SW;
      period_q <= '0; cmp_q <= 1'b0; ovr_q <= 1'b0; irq <= 1'b0;
    end else begin
      sw_q <= wr_ctl && reg_wdata[4];
      if (wr_ctl) begin
        cont_q <= reg_wdata[0];
        src_q  <= trig_src_t'(reg_wdata[2:1]);
        ie_q   <= reg_wdata[3];
      end
      if (wr_tmr) period_q <= reg_wdata[TMR_W-1:0];
      cmp_q <= cmp_d;
      ovr_q <= (trig && busy) || (ovr_q && !(wr_sts && reg_wdata[1]));
      irq   <= cmp_d && ie_q;
    end
  end

  qseq_trigger #(.TMR_W(TMR_W)) u_trig (
    .clk(clk), .rst(rst), .src(src_q), .sw_start(sw_q),
    .ext_pin(ext_trig), .period(period_q), .trig(trig)
  );

  qseq_sdp_ram #(.DW(CCW_W), .AW(IDX_W)) u_ccw_mem (
    .clk(clk), .we(wr_ccw), .waddr(reg_addr[IDX_W-1:0]),
    .wdata(reg_wdata[CCW_W-1:0]), .raddr(ccw_raddr), .rdata(ccw_rdata)
  );

  qseq_sdp_ram #(.DW(RES_W), .AW(IDX_W)) u_res_mem (
    .clk(clk), .we(res_we), .waddr(res_waddr), .wdata(res_wdata),
    .raddr(reg_addr[IDX_W-1:0]), .rdata(res_rdata)
  );

  qseq_engine #(.IDX_W(IDX_W)) u_eng (
    .clk(clk), .rst(rst), .start(trig), .cont_mode(cont_q),
    .ccw_addr(ccw_raddr), .ccw_data(ccw_rdata),
    .res_we(res_we), .res_addr(res_waddr), .res_wdata(res_wdata),
    .busy(busy), .pass_done(pass_done), .idx_o(idx),
    .cv_sample(cv_sample), .cv_start(cv_start), .cv_chan(cv_chan),
    .cv_done(cv_done), .cv_result(cv_result)
  );

  always_comb begin
    csr_d = '0;
    unique case (off)
      A_CTL:   csr_d[3:0] = {ie_q, src_q, cont_q};
      A_STS:   begin
        csr_d[1:0]         = {ovr_q, cmp_q};
        csr_d[8 +: IDX_W]  = idx;
      end
      A_TMR:   csr_d[TMR_W-1:0] = period_q;
      default: csr_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      region_q <= RG_CSR; view_q <= 2'd0; csr_q <= '0;
    end else begin
      region_q <= region;
      view_q   <= reg_addr[IDX_W +: 2];
      csr_q    <= (region == RG_CSR) ? csr_d : '0;
    end
  end

  always_comb begin
    reg_rdata = csr_q;
    if (region_q == RG_RES) begin
      unique case (view_q)
        2'd0:    reg_rdata = {{PAD_W{1'b0}}, res_rdata};
        2'd1:    reg_rdata = {res_rdata, {PAD_W{1'b0}}};
        2'd2:    reg_rdata = {~res_rdata[RES_W-1], res_rdata[RES_W-2:0], {PAD_W{1'b0}}};
        default: reg_rdata = '0;
      endcase
    end else if (region_q == RG_CCW) begin
      reg_rdata = '0;
    end
  end

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(ie_q)); // R7
  AST_CMP_FROM_PASS: assert property (@(posedge clk) disable iff (rst)
    $rose(cmp_q) |-> $past(pass_done)); // R7
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (ovr_q && !(wr_sts && reg_wdata[1])) |=> ovr_q); // R9
  AST_SINGLE_STOPS: assert property (@(posedge clk) disable iff (rst)
    (pass_done && !cont_q && !$past(trig)) |=> !cv_sample); // R4
endmodule

// File: tb/test_adc_cmd_sequencer.sv
module test_adc_cmd_sequencer;
  logic clk = 1'b0, rst = 1'b1;
  logic [9:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        ext_trig = 1'b0;
  logic        cv_sample, cv_start, cv_done, irq;
  logic [5:0]  cv_chan;
  logic [9:0]  cv_result;

  int total = 0, bad = 0, nconv = 0, scnt = 0, cyc = 0, t_first = 0;
  bit arm_t = 0;
  logic [16:0] sb_q[$];
  logic [9:0]  exp_res [64];

  always #10 clk = ~clk;
  always @(posedge clk) cyc++;

  adc_cmd_sequencer i_adc_cmd_sequencer (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_trig(ext_trig),
    .cv_sample(cv_sample), .cv_start(cv_start), .cv_chan(cv_chan),
    .cv_done(cv_done), .cv_result(cv_result), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input int ch, input int code, input int idx);
    sb_q.push_back({6'(idx), 5'(2 << code), 6'(ch)});
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_addr = 10'(a); reg_wdata = 16'(d); reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = 10'(a);
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic wait_cmp(input string req);
    logic [15:0] s;
    s = '0;
    for (int k = 0; k < 3000 && !s[0]; k++) rd(10'h001, s);
    chk(req, s[0], 1);
  endtask

  // converter model and scoreboard monitor
  initial begin
    cv_done = 1'b0; cv_result = '0;
    forever begin
      @(negedge clk);
      if (cv_sample) scnt++;
      if (cv_start) begin
        logic [16:0] it;
        logic [9:0]  r;
        if (arm_t) begin t_first = cyc; arm_t = 0; end
        if (sb_q.size() == 0) begin
          bad++; total++;
          $display("FAIL R2 unexpected conversion actual=ch%0d expected=none", cv_chan);
        end else begin
          it = sb_q.pop_front();
          chk("R1 channel", cv_chan, it[5:0]);
          chk("R1 sample length", scnt, it[10:6]);
          r = 10'(cv_chan * 37 + nconv * 11);
          exp_res[it[16:11]] = r;
        end
        nconv++;
        scnt = 0;
        repeat (3) @(negedge clk);
        cv_result = 10'(cv_chan * 37 + (nconv - 1) * 11);
        cv_done = 1'b1;
        @(negedge clk);
        cv_done = 1'b0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] d;
    int base;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R12 reset state
    rd(10'h001, d); chk("R12 status", d, 0);
    rd(10'h000, d); chk("R12 control", d, 0);
    chk("R12 irq", irq, 0);
    chk("R12 sample/start", {cv_sample, cv_start}, 0);

    // single software scan, R1 codes 3,0,1
    wr(10'h100, 16'h00F9); wr(10'h101, 16'h0005);
    wr(10'h102, 16'h004C); wr(10'h103, 16'h003F);
    push(57, 3, 0); push(5, 0, 1); push(12, 1, 2);
    base = nconv;
    wr(10'h000, 16'h0018);
    wait_cmp("R7 complete");
    chk("R2 end code no conversion", nconv - base, 3);
    chk("R7 irq enabled", irq, 1);
    rd(10'h001, d); chk("R11 index at end", d[13:8], 3);
    for (int i = 0; i < 3; i++) begin
      rd(10'h200 + i, d); chk("R3 right view", d, {6'b0, exp_res[i]});
    end
    rd(10'h240, d); chk("R8 left unsigned", d, {exp_res[0], 6'b0});
    rd(10'h281, d); chk("R8 left signed", d, {~exp_res[1][9], exp_res[1][8:0], 6'b0});
    repeat (60) @(negedge clk);
    chk("R4 single pass stays idle", nconv - base, 3);
    wr(10'h001, 16'h0001);
    @(negedge clk);
    chk("R7 irq after clear", irq, 0);
    rd(10'h001, d); chk("R7 complete cleared", d[0], 0);

    // R9 overrun
    push(57, 3, 0); push(5, 0, 1); push(12, 1, 2);
    base = nconv;
    wr(10'h000, 16'h0018);
    repeat (5) @(negedge clk);
    wr(10'h000, 16'h0018);
    wait_cmp("R9 pass completes");
    repeat (40) @(negedge clk);
    chk("R9 retrigger ignored", nconv - base, 3);
    rd(10'h001, d); chk("R9 overrun set", d[1], 1);
    wr(10'h001, 16'h0003);
    rd(10'h001, d); chk("R9 flags cleared", d[1:0], 0);

    // R6 start bit ignored when pin source selected
    base = nconv;
    wr(10'h000, 16'h0012);
    repeat (40) @(negedge clk);
    chk("R6 unselected start ignored", nconv - base, 0);
    rd(10'h001, d); chk("R6 no completion", d[0], 0);

    // R6 pin edge, irq disabled
    push(57, 3, 0); push(5, 0, 1); push(12, 1, 2);
    @(negedge clk); ext_trig = 1'b1;
    repeat (3) @(negedge clk); ext_trig = 1'b0;
    wait_cmp("R6 pin trigger");
    chk("R6 pin scan count", nconv - base, 3);
    chk("R7 irq masked", irq, 0);
    wr(10'h001, 16'h0001);

    // R6 interval timer
    push(57, 3, 0); push(5, 0, 1); push(12, 1, 2);
    wr(10'h002, 300);
    arm_t = 1;
    base = cyc;
    wr(10'h000, 16'h0004);
    wait_cmp("R6 timer trigger");
    wr(10'h000, 16'h0006);
    chk("R6 timer delay", (t_first - base >= 300) && (t_first - base <= 340), 1);
    repeat (40) @(negedge clk);
    chk("R6 timer one pass", sb_q.size(), 0);
    wr(10'h001, 16'h0001);

    // R5 continuous scan stopped mid-pass
    wr(10'h100, 16'h0003); wr(10'h101, 16'h0004); wr(10'h102, 16'h003F);
    for (int p = 0; p < 3; p++) begin push(3, 0, 0); push(4, 0, 1); end
    base = nconv;
    wr(10'h000, 16'h0011);
    wait (nconv == base + 4);
    wr(10'h000, 16'h0000);
    repeat (200) @(negedge clk);
    chk("R5 pass finished then stopped", nconv - base, 4);
    chk("R5 third pass not started", sb_q.size(), 2);
    sb_q.delete();
    rd(10'h001, d);
    chk("R5 complete set", d[0], 1);
    chk("R11 index at end code", d[13:8], 2);
    rd(10'h201, d); chk("R3 index 1 result", d, {6'b0, exp_res[1]});
    wr(10'h001, 16'h0001);

    // R10 full table without end code
    for (int i = 0; i < 64; i++) begin
      wr(10'h100 + i, (i * 5) % 63);
      push((i * 5) % 63, 0, i);
    end
    base = nconv;
    wr(10'h000, 16'h0010);
    wait_cmp("R10 ends at last index");
    repeat (40) @(negedge clk);
    chk("R10 conversions", nconv - base, 64);
    rd(10'h001, d); chk("R10 index 63", d[13:8], 63);
    rd(10'h23F, d); chk("R3 index 63 result", d, {6'b0, exp_res[63]});
    rd(10'h27F, d); chk("R8 left index 63", d, {exp_res[63], 6'b0});

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule